// File: doc/BRIEF.md
# Bit-Oriented Frame Transmitter

This block turns a stream of tagged characters into a bit-oriented serial frame. Software-side logic writes one character at a time into a single holding register, together with three qualifiers: open a frame, close a frame, or abort. A shift engine moves characters from the holding register to the line. Each bit advances on a single-cycle `bit_tick` strobe that stands in for the external transmit clock. The engine adds the opening and closing flags and inserts a zero after every run of five ones in the payload. Between frames the line idles with either back-to-back flags or a steady mark (ones).

The writer learns that it may supply the next character when `buf_empty` goes high. If it is too slow and the engine needs a character in the middle of a frame, the engine sends an abort instead, returns to idle and raises `data_late`. `tx_active` shows when a frame occupies the line. `tx_en` keeps new frames from starting and holds the line at mark.

Top module: `bitframe_tx`

## Requirements
- R1: After reset, `txd`=1, `buf_empty`=1, `tx_active`=0 and `data_late`=0.
- R2: A write (`wr_valid`=1) while `buf_empty`=1 is accepted and drops `buf_empty` on the next cycle. A write while `buf_empty`=0 is ignored and leaves the held character unchanged.
- R3: A payload character sends `len_code`+1 bits of `wr_data`, least significant bit first (so `len_code`=7 sends 8 bits). Bits above that length are not sent.
- R4: When a character tagged `wr_som` reaches the engine while no frame is open, a flag is sent first, on the line in the order 0,1,1,1,1,1,1,0 (0x7E), and the character follows it.
- R5: A character tagged `wr_eom` is followed directly by a closing flag 0,1,1,1,1,1,1,0. Only a stuffed zero may come between them.
- R6: Inside a frame, a single 0 is sent after every five consecutive payload 1s, counting across character boundaries. Flags and aborts are never stuffed.
- R7: A character tagged `wr_abort` is consumed and replaced on the line by eight consecutive 1s, and the frame ends.
- R8: If the holding register is empty when a mid-frame character is needed, the engine sends eight 1s, returns to idle and sets `data_late`. `data_late` stays set until the next accepted write.
- R9: With no frame open and `idle_flag_sel`=1, the line carries back-to-back flags. With `idle_flag_sel`=0 it carries 1s.
- R10: While `tx_en`=0, no frame starts, the line sends 1s and a held character stays held.
- R11: A character without `wr_som` that reaches the engine while no frame is open is discarded, and the line stays idle.
- R12: `tx_active` is 1 from the first bit of an opening flag through the last bit of the closing flag or abort. It is 0 while idling.
- R13: `txd` changes only in a cycle following one with `bit_tick`=1. The first bit of a frame is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe, one per line bit |
| tx_en | input | 1 | Allows frames to start; 0 forces mark |
| idle_flag_sel | input | 1 | Idle fill: 1 flags, 0 ones |
| len_code | input | LEN_W (3) | Character length minus one |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W (8) | Character to send |
| wr_som | input | 1 | Character opens a frame |
| wr_eom | input | 1 | Character closes the frame |
| wr_abort | input | 1 | Send abort in place of this character |
| buf_empty | output | 1 | Holding register can accept a write |
| data_late | output | 1 | Sticky underrun indication |
| tx_active | output | 1 | A frame occupies the line |
| txd | output | 1 | Serial line output |

## Verification
The underrun path is the hardest case to reach from the ports. It needs the holding register to be empty at the exact bit boundary where the engine wants the next payload character, while a frame is open. The bench opens a frame with a single character that carries no end tag and then withholds further writes, so the boundary after that character finds nothing. Stuffing across a character boundary and just before the closing flag is reached with all-ones payloads at full and reduced character length. The expected line pattern for each case, including the trailing abort ones, is queued before the writes are issued.

// File: rtl/bft_pkg.sv
package bft_pkg;

   typedef enum logic [2:0] {
      U_MARK      = 3'd0,
      U_IDLE_FLAG = 3'd1,
      U_OPEN      = 3'd2,
      U_DATA      = 3'd3,
      U_CLOSE     = 3'd4,
      U_ABORT     = 3'd5
   } unit_e;

   typedef struct packed {
      logic som;
      logic eom;
      logic abort;
   } tag_t;

   localparam logic [7:0] FLAG_BYTE = 8'h7E;

endpackage

// File: rtl/bft_hold_buf.sv
module bft_hold_buf
   import bft_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  tag_t              wr_tag,
   input  logic              take,
   output logic              wr_accept,
   output logic              valid,
   output logic [DATA_W-1:0] data,
   output tag_t              tag
);

   logic              valid_q;
   logic [DATA_W-1:0] data_q;
   tag_t              tag_q;

   assign wr_accept = wr_valid && !valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
         tag_q   <= '0;
      end else if (wr_accept) begin
         valid_q <= 1'b1;
         data_q  <= wr_data;
         tag_q   <= wr_tag;
      end else if (take) begin
         valid_q <= 1'b0;
      end
   end

   assign valid = valid_q;
   assign data  = data_q;
   assign tag   = tag_q;

endmodule

// File: rtl/bft_unit_sel.sv
module bft_unit_sel
   import bft_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ABORT_ONES = 8,
   parameter bit LSB_FIRST  = 1'b1,
   parameter int LEN_W      = 3,
   parameter int CNT_W      = 4
) (
   input  logic              tx_en,
   input  logic              idle_flag_sel,
   input  logic [LEN_W-1:0]  len_code,
   input  unit_e             cur_kind,
   input  logic              cur_eom,
   input  logic              in_frame,
   input  logic              hold_valid,
   input  logic [DATA_W-1:0] hold_data,
   input  tag_t              hold_tag,
   output unit_e             nxt_kind,
   output logic [DATA_W-1:0] nxt_pat,
   output logic [CNT_W-1:0]  nxt_nbits,
   output logic              nxt_eom,
   output logic              nxt_in_frame,
   output logic              take,
   output logic              late
);

   logic [DATA_W-1:0] flag_pat;
   logic [DATA_W-1:0] data_pat;
   logic [CNT_W-1:0]  char_bits;

   assign char_bits = CNT_W'(len_code) + CNT_W'(1);

   generate
      if (LSB_FIRST) begin : g_lsb
         assign flag_pat = DATA_W'(FLAG_BYTE);
         assign data_pat = hold_data;
      end else begin : g_msb
         assign flag_pat = DATA_W'(FLAG_BYTE) << (DATA_W - 8);
         assign data_pat = hold_data << (CNT_W'(DATA_W) - char_bits);
      end
   endgenerate

   always_comb begin
      nxt_kind     = U_MARK;
      nxt_pat      = '1;
      nxt_nbits    = CNT_W'(8);
      nxt_eom      = 1'b0;
      nxt_in_frame = 1'b0;
      take         = 1'b0;
      late         = 1'b0;
      if (!tx_en) begin
         nxt_kind = U_MARK;
      end else if (in_frame) begin
         if (cur_kind == U_DATA && cur_eom) begin
            nxt_kind = U_CLOSE;
            nxt_pat  = flag_pat;
         end else if (hold_valid) begin
            take = 1'b1;
            if (hold_tag.abort) begin
               nxt_kind  = U_ABORT;
               nxt_nbits = CNT_W'(ABORT_ONES);
            end else begin
               nxt_kind     = U_DATA;
               nxt_pat      = data_pat;
               nxt_nbits    = char_bits;
               nxt_eom      = hold_tag.eom;
               nxt_in_frame = 1'b1;
            end
         end else begin
            late      = 1'b1;
            nxt_kind  = U_ABORT;
            nxt_nbits = CNT_W'(ABORT_ONES);
         end
      end else if (hold_valid && hold_tag.abort) begin
         take      = 1'b1;
         nxt_kind  = U_ABORT;
         nxt_nbits = CNT_W'(ABORT_ONES);
      end else if (hold_valid && hold_tag.som) begin
         nxt_kind     = U_OPEN;
         nxt_pat      = flag_pat;
         nxt_in_frame = 1'b1;
      end else begin
         take = hold_valid;
         if (idle_flag_sel) begin
            nxt_kind = U_IDLE_FLAG;
            nxt_pat  = flag_pat;
         end
      end
   end

endmodule

// File: rtl/bft_serializer.sv
module bft_serializer
   import bft_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int STUFF_RUN = 5,
   parameter bit LSB_FIRST = 1'b1,
   parameter int CNT_W     = 4,
   parameter int ONES_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  unit_e             nxt_kind,
   input  logic [DATA_W-1:0] nxt_pat,
   input  logic [CNT_W-1:0]  nxt_nbits,
   input  logic              nxt_eom,
   input  logic              nxt_in_frame,
   output logic              unit_load,
   output unit_e             cur_kind,
   output logic              cur_eom,
   output logic              in_frame,
   output logic              tx_active,
   output logic              txd
);

   logic [DATA_W-1:0] sh_q;
   logic [CNT_W-1:0]  left_q;
   unit_e             kind_q;
   logic              eom_q;
   logic              frame_q;
   logic              txd_q;
   logic              act_q;
   logic [ONES_W-1:0] ones_q;

   logic              stuff;
   logic              first_nxt;
   logic              first_cur;
   logic [DATA_W-1:0] rest_nxt;
   logic [DATA_W-1:0] rest_cur;

   assign stuff     = (kind_q == U_DATA) && (ones_q == ONES_W'(STUFF_RUN));
   assign unit_load = bit_tick && !stuff && (left_q == '0);

   generate
      if (LSB_FIRST) begin : g_lsb
         assign first_nxt = nxt_pat[0];
         assign first_cur = sh_q[0];
         assign rest_nxt  = nxt_pat >> 1;
         assign rest_cur  = sh_q >> 1;
      end else begin : g_msb
         assign first_nxt = nxt_pat[DATA_W-1];
         assign first_cur = sh_q[DATA_W-1];
         assign rest_nxt  = nxt_pat << 1;
         assign rest_cur  = sh_q << 1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         left_q  <= '0;
         kind_q  <= U_MARK;
         eom_q   <= 1'b0;
         frame_q <= 1'b0;
         txd_q   <= 1'b1;
         act_q   <= 1'b0;
         ones_q  <= '0;
      end else if (bit_tick) begin
         if (stuff) begin
            txd_q  <= 1'b0;
            ones_q <= '0;
         end else if (left_q == '0) begin
            kind_q  <= nxt_kind;
            eom_q   <= nxt_eom;
            frame_q <= nxt_in_frame;
            txd_q   <= first_nxt;
            sh_q    <= rest_nxt;
            left_q  <= nxt_nbits - CNT_W'(1);
            ones_q  <= (nxt_kind == U_DATA && first_nxt) ? ones_q + ONES_W'(1) : '0;
            if (nxt_kind == U_OPEN) begin
               act_q <= 1'b1;
            end else if (nxt_kind == U_MARK || nxt_kind == U_IDLE_FLAG) begin
               act_q <= 1'b0;
            end
         end else begin
            txd_q  <= first_cur;
            sh_q   <= rest_cur;
            left_q <= left_q - CNT_W'(1);
            ones_q <= (kind_q == U_DATA && first_cur) ? ones_q + ONES_W'(1) : '0;
         end
      end
   end

   assign cur_kind  = kind_q;
   assign cur_eom   = eom_q;
   assign in_frame  = frame_q;
   assign tx_active = act_q;
   assign txd       = txd_q;

endmodule

// File: rtl/bitframe_tx.sv
module bitframe_tx
   import bft_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ABORT_ONES = 8,
   parameter int STUFF_RUN  = 5,
   parameter bit LSB_FIRST  = 1'b1,
   localparam int LEN_W     = $clog2(DATA_W),
   localparam int CNT_W     = $clog2(DATA_W + 1),
   localparam int ONES_W    = $clog2(STUFF_RUN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              tx_en,
   input  logic              idle_flag_sel,
   input  logic [LEN_W-1:0]  len_code,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_som,
   input  logic              wr_eom,
   input  logic              wr_abort,
   output logic              buf_empty,
   output logic              data_late,
   output logic              tx_active,
   output logic              txd
);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must hold a whole flag");
      end
      if (ABORT_ONES < 7 || ABORT_ONES > DATA_W) begin : g_bad_abort
         $error("ABORT_ONES must lie between 7 and DATA_W");
      end
      if (STUFF_RUN < 1) begin : g_bad_run
         $error("STUFF_RUN must be positive");
      end
   endgenerate

   tag_t              wr_tag;
   tag_t              hold_tag;
   logic              hold_valid;
   logic [DATA_W-1:0] hold_data;
   logic              wr_accept;
   logic              sel_take;
   logic              sel_late;
   logic              unit_load;
   unit_e             cur_kind;
   logic              cur_eom;
   logic              in_frame;
   unit_e             nxt_kind;
   logic [DATA_W-1:0] nxt_pat;
   logic [CNT_W-1:0]  nxt_nbits;
   logic              nxt_eom;
   logic              nxt_in_frame;
   logic              late_q;

   assign wr_tag = '{som: wr_som, eom: wr_eom, abort: wr_abort};

   bft_hold_buf #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (wr_valid),
      .wr_data   (wr_data),
      .wr_tag    (wr_tag),
      .take      (unit_load && sel_take),
      .wr_accept (wr_accept),
      .valid     (hold_valid),
      .data      (hold_data),
      .tag       (hold_tag)
   );

   bft_unit_sel #(
      .DATA_W     (DATA_W),
      .ABORT_ONES (ABORT_ONES),
      .LSB_FIRST  (LSB_FIRST),
      .LEN_W      (LEN_W),
      .CNT_W      (CNT_W)
   ) u_sel (
      .tx_en        (tx_en),
      .idle_flag_sel(idle_flag_sel),
      .len_code     (len_code),
      .cur_kind     (cur_kind),
      .cur_eom      (cur_eom),
      .in_frame     (in_frame),
      .hold_valid   (hold_valid),
      .hold_data    (hold_data),
      .hold_tag     (hold_tag),
      .nxt_kind     (nxt_kind),
      .nxt_pat      (nxt_pat),
      .nxt_nbits    (nxt_nbits),
      .nxt_eom      (nxt_eom),
      .nxt_in_frame (nxt_in_frame),
      .take         (sel_take),
      .late         (sel_late)
   );

   bft_serializer #(
      .DATA_W    (DATA_W),
      .STUFF_RUN (STUFF_RUN),
      .LSB_FIRST (LSB_FIRST),
      .CNT_W     (CNT_W),
      .ONES_W    (ONES_W)
   ) u_ser (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_tick     (bit_tick),
      .nxt_kind     (nxt_kind),
      .nxt_pat      (nxt_pat),
      .nxt_nbits    (nxt_nbits),
      .nxt_eom      (nxt_eom),
      .nxt_in_frame (nxt_in_frame),
      .unit_load    (unit_load),
      .cur_kind     (cur_kind),
      .cur_eom      (cur_eom),
      .in_frame     (in_frame),
      .tx_active    (tx_active),
      .txd          (txd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         late_q <= 1'b0;
      end else if (unit_load && sel_late) begin
         late_q <= 1'b1;
      end else if (wr_accept) begin
         late_q <= 1'b0;
      end
   end

   assign buf_empty = !hold_valid;
   assign data_late = late_q;

endmodule

// File: rtl/bft_checker.sv
module bft_checker (
   input logic clk,
   input logic rst_n,
   input logic bit_tick,
   input logic tx_en,
   input logic wr_valid,
   input logic buf_empty,
   input logic data_late,
   input logic tx_active,
   input logic txd
);

   AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(txd));                                   // R13

   AST_FRAME_STARTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_active) |-> !txd);                                    // R13

   AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_active) |-> $past(tx_en) && $past(bit_tick));         // R10

   AST_LATE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_late) |-> $past(tx_active));                        // R8

   AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_empty && wr_valid) |=> !buf_empty);                       // R2

   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_empty && !bit_tick) |=> !buf_empty);                     // R2

endmodule

bind bitframe_tx bft_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_tick  (bit_tick),
   .tx_en     (tx_en),
   .wr_valid  (wr_valid),
   .buf_empty (buf_empty),
   .data_late (data_late),
   .tx_active (tx_active),
   .txd       (txd)
);

// File: tb/bitframe_tx_tb.sv
`timescale 1ns/1ps
module bitframe_tx_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       tx_en = 1'b0;
   logic       idle_flag_sel = 1'b0;
   logic [2:0] len_code = 3'd7;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       wr_som = 1'b0;
   logic       wr_eom = 1'b0;
   logic       wr_abort = 1'b0;
   logic       buf_empty;
   logic       data_late;
   logic       tx_active;
   logic       txd;

   int    n_chk = 0;
   int    n_bad = 0;
   int    tick_div = 0;
   int    ones_m = 0;
   bit    exp_q[$];
   bit    hunting = 1'b1;
   bit    mon_on = 1'b1;
   bit    done = 1'b0;
   string cur_req = "R4";

   always #2 clk = ~clk;

   bitframe_tx u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_tick     (bit_tick),
      .tx_en        (tx_en),
      .idle_flag_sel(idle_flag_sel),
      .len_code     (len_code),
      .wr_valid     (wr_valid),
      .wr_data      (wr_data),
      .wr_som       (wr_som),
      .wr_eom       (wr_eom),
      .wr_abort     (wr_abort),
      .buf_empty    (buf_empty),
      .data_late    (data_late),
      .tx_active    (tx_active),
      .txd          (txd)
   );

   initial begin
      forever begin
         @(negedge clk);
         tick_div = (tick_div + 1) % 4;
         bit_tick = (tick_div == 0);
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic push_flag();
      ones_m = 0;
      for (int i = 0; i < 8; i++) exp_q.push_back(bit'((8'h7E >> i) & 1));
   endtask

   task automatic push_ones(input int n);
      ones_m = 0;
      for (int i = 0; i < n; i++) exp_q.push_back(1'b1);
   endtask

   task automatic push_char(input logic [7:0] d, input int nb);
      for (int i = 0; i < nb; i++) begin
         exp_q.push_back(d[i]);
         if (d[i]) ones_m++; else ones_m = 0;
         if (ones_m == 5) begin
            exp_q.push_back(1'b0);
            ones_m = 0;
         end
      end
   endtask

   task automatic pulse_write(input logic [7:0] d, input logic s, input logic e, input logic a);
      wr_valid = 1'b1; wr_data = d; wr_som = s; wr_eom = e; wr_abort = a;
      @(negedge clk);
      wr_valid = 1'b0; wr_som = 1'b0; wr_eom = 1'b0; wr_abort = 1'b0;
   endtask

   task automatic write_char(input logic [7:0] d, input logic s, input logic e, input logic a);
      @(negedge clk);
      while (!buf_empty) @(negedge clk);
      pulse_write(d, s, e, a);
   endtask

   task automatic wait_tick();
      do @(posedge clk); while (!bit_tick);
      @(negedge clk);
   endtask

   task automatic wait_frame();
      @(negedge clk);
      while (!(exp_q.size() == 0 && hunting)) @(negedge clk);
   endtask

   // Monitor: hunts for the first 0 of a frame and compares against the queue
   initial begin
      bit   ticked;
      bit   b;
      logic last_txd;
      wait (rst_n);
      @(negedge clk);
      last_txd = txd;
      forever begin
         @(posedge clk);
         ticked = bit_tick;
         @(negedge clk);
         if (!ticked) chk("R13 line steady between ticks", txd, last_txd);
         last_txd = txd;
         if (ticked && mon_on) begin
            if (hunting && txd == 1'b0) begin
               if (exp_q.size() == 0) chk("R11 unexpected frame start", txd, 1'b1);
               else hunting = 1'b0;
            end
            if (!hunting) begin
               b = exp_q.pop_front();
               chk(cur_req, txd, b);
               chk("R12 active during frame", tx_active, 1'b1);
               if (exp_q.size() == 0) hunting = 1'b1;
            end
         end
      end
   end

   initial begin
      #(150000 * 4);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (R1..R13 run): actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      bit       cap[24];
      int       at;
      logic [7:0] got;
      repeat (5) @(negedge clk);
      chk("R1 txd idle", txd, 1'b1);
      chk("R1 buf_empty", buf_empty, 1'b1);
      chk("R1 tx_active", tx_active, 1'b0);
      chk("R1 data_late", data_late, 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 txd after release", txd, 1'b1);

      // R3 R4 R5: two-character frame, full length
      tx_en = 1'b1;
      repeat (4) wait_tick();
      cur_req = "R4/R5 basic frame";
      push_flag(); push_char(8'h5A, 8); push_char(8'h3C, 8); push_flag();
      write_char(8'h5A, 1, 0, 0);
      write_char(8'h3C, 0, 1, 0);
      wait_frame();
      wait_tick();
      chk("R12 idle after frame", tx_active, 1'b0);

      // R6: stuffing across a character boundary
      cur_req = "R6 stuffing across chars";
      push_flag(); push_char(8'hFF, 8); push_char(8'hFF, 8); push_flag();
      write_char(8'hFF, 1, 0, 0);
      write_char(8'hFF, 0, 1, 0);
      wait_frame();

      // R3 R6: five-bit characters, stuff bit right before closing flag
      len_code = 3'd4;
      cur_req = "R3 short chars, R6 stuff before flag";
      push_flag(); push_char(8'h03, 5); push_char(8'h1F, 5); push_flag();
      write_char(8'hE3, 1, 0, 0);
      write_char(8'h1F, 0, 1, 0);
      wait_frame();
      len_code = 3'd7;

      // R7: abort tag
      cur_req = "R7 abort tag";
      push_flag(); push_char(8'h12, 8); push_ones(8);
      write_char(8'h12, 1, 0, 0);
      write_char(8'h00, 0, 0, 1);
      wait_frame();
      repeat (3) wait_tick();
      chk("R7 no late on abort", data_late, 1'b0);

      // R8: underrun
      cur_req = "R8 underrun abort";
      push_flag(); push_char(8'h81, 8); push_ones(8);
      write_char(8'h81, 1, 0, 0);
      wait_frame();
      repeat (3) wait_tick();
      chk("R8 data_late set", data_late, 1'b1);
      chk("R12 idle after underrun", tx_active, 1'b0);

      // R10 R2: disabled transmitter holds the character, second write ignored
      tx_en = 1'b0;
      repeat (10) wait_tick();
      write_char(8'h66, 1, 1, 0);
      chk("R8 late cleared by write", data_late, 1'b0);
      chk("R2 buffer full", buf_empty, 1'b0);
      pulse_write(8'h99, 1, 1, 0);
      repeat (20) wait_tick();
      chk("R10 no frame while disabled", tx_active, 1'b0);
      chk("R10 line mark", txd, 1'b1);
      chk("R2 still full", buf_empty, 1'b0);
      cur_req = "R2/R10 held char sent";
      push_flag(); push_char(8'h66, 8); push_flag();
      tx_en = 1'b1;
      wait_frame();
      chk("R2 buffer drained", buf_empty, 1'b1);

      // R11: untagged character while idle is dropped
      write_char(8'h00, 0, 0, 0);
      repeat (20) wait_tick();
      chk("R11 discarded", buf_empty, 1'b1);
      chk("R11 stays idle", tx_active, 1'b0);

      // R9: flag idle
      mon_on = 1'b0;
      idle_flag_sel = 1'b1;
      repeat (12) wait_tick();
      for (int i = 0; i < 24; i++) begin
         wait_tick();
         cap[i] = txd;
      end
      at = -1;
      for (int i = 0; i < 15; i++) begin
         if (at < 0 && cap[i] == 1'b0 && cap[i+1] == 1'b1) at = i;
      end
      got = 8'h00;
      if (at >= 0) begin
         for (int k = 0; k < 8; k++) got[k] = cap[at + k];
      end
      chk("R9 idle flags", got, 8'h7E);
      chk("R9 no frame while flag idling", tx_active, 1'b0);
      idle_flag_sel = 1'b0;
      repeat (12) wait_tick();
      chk("R9 mark idle", txd, 1'b1);
      mon_on = 1'b1;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule